// File: doc/BRIEF.md
# Dual-Port RAM with Selectable Write Mode and Collision Flag

A synchronous RAM with two symmetric ports, A and B. Each port can write one word and read one word on every rising edge of its own clock. Each port has its own write enable, write address, read address, write data, registered read data and synchronous reset. A build-time parameter sets what a port returns when it reads the address it is writing in the same cycle: either the word held before the write (read-first) or the word being written (write-through). An optional output register adds one cycle of read latency.

A collision output reports a cross-port conflict. This is a cycle where an address written by one port equals an address written or read by the other port. Such a conflict is flagged, not resolved silently. A read that collides returns no defined data. The one exception is two writes to the same address: port A wins. Collision detection assumes both ports run from one clock. Preload contents come from a packed parameter image.

The storage holds two banks, one written only by each port. The stored word is the XOR of the two banks. A port writes its data XOR the other bank's current word. This keeps every array driven from a single clock process.

The ports carry no valid/ready handshake. Every port accepts a request on every edge and never applies back-pressure. Read data is a registered stream that follows the read address at a fixed latency.

Top module: `twin_port_ram`

## Requirements
- R1: With write enable high on a rising edge, a port stores its write data at its write address. Any later read of that address, from either port, returns it. With OUT_REG=0, read data shows the word at the read address one edge after the address is presented.
- R2: In read-first mode (WMODE=0), a port reading the address it writes on the same edge returns the word stored before that write.
- R3: In write-through mode (WMODE=1), a port reading the address it writes on the same edge returns the new write data.
- R4: collide_o is high, at the read latency after the edge, when the inputs at that edge meet either condition. Condition one: one port writes and its write address equals the other port's read address. Condition two: both ports write and their write addresses match.
- R5: collide_o is low, at the read latency, after an edge where neither condition of R4 holds.
- R6: When both ports write the same address on one edge, port A's data is stored.
- R7: With OUT_REG=1, read data and collide_o arrive one edge later than with OUT_REG=0.
- R8: A synchronous reset clears a port's read data, including the output stage, to zero. rst_a also clears collide_o.
- R9: At start, word i holds INIT_IMAGE bits [i*DW +: DW].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Port A clock, rising edge; also clocks collision logic |
| rst_a | input | 1 | Port A synchronous reset, active high |
| we_a | input | 1 | Port A write enable |
| waddr_a | input | AW | Port A write address |
| raddr_a | input | AW | Port A read address |
| wdata_a | input | DW | Port A write data |
| rdata_a | output | DW | Port A registered read data |
| clk_b | input | 1 | Port B clock, rising edge |
| rst_b | input | 1 | Port B synchronous reset, active high |
| we_b | input | 1 | Port B write enable |
| waddr_b | input | AW | Port B write address |
| raddr_b | input | AW | Port B read address |
| wdata_b | input | DW | Port B write data |
| rdata_b | output | DW | Port B registered read data |
| collide_o | output | 1 | Cross-port collision flag, aligned with read data |

## Verification
Read data and the collision flag are due one edge after the request with OUT_REG=0, and two edges after it with OUT_REG=1. The bench drives two instances with the same stimulus: a write-through one without the output stage and a read-first one with it. Inputs change on falling edges. The bench computes each expected word from a shadow memory when the request is issued. It queues that value in a one-stage pipeline for the fast instance and a two-stage pipeline for the slow one. It compares each value on the falling edge where it is due. Read data is skipped on cycles whose expected collision is high. The flag itself is checked on every cycle.

// File: rtl/tpr_pkg.sv
package tpr_pkg;
  typedef enum logic {
    WM_READ_FIRST    = 1'b0,
    WM_WRITE_THROUGH = 1'b1
  } wmode_e;
endpackage

// File: rtl/tpr_bank.sv
// One storage bank, written by a single port, with three asynchronous taps.
module tpr_bank #(
  parameter int AW = 10,
  parameter int DW = 16,
  parameter logic [(1<<AW)*DW-1:0] INIT_IMAGE = '0
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wword,
  input  logic [AW-1:0] tap0_addr,
  input  logic [AW-1:0] tap1_addr,
  input  logic [AW-1:0] tap2_addr,
  output logic [DW-1:0] tap0_word,
  output logic [DW-1:0] tap1_word,
  output logic [DW-1:0] tap2_word
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) cells[i] = INIT_IMAGE[i*DW +: DW];
  end

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wword;
  end

  assign tap0_word = cells[tap0_addr];
  assign tap1_word = cells[tap1_addr];
  assign tap2_word = cells[tap2_addr];
endmodule

// File: rtl/tpr_rdport.sv
// Read register with same-port forwarding and optional output stage.
module tpr_rdport
  import tpr_pkg::*;
#(
  parameter int     AW      = 10,
  parameter int     DW      = 16,
  parameter wmode_e WMODE   = WM_READ_FIRST,
  parameter bit     OUT_REG = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [AW-1:0] raddr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] word,
  output logic [DW-1:0] rdata
);
  logic          fwd;
  logic [DW-1:0] next_word;
  logic [DW-1:0] rd_q;

  assign fwd       = (WMODE == WM_WRITE_THROUGH) && we && (waddr == raddr);
  assign next_word = fwd ? wdata : word;

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= next_word;
  end

  generate
    if (OUT_REG) begin : g_out
      logic [DW-1:0] out_q;
      always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= rd_q;
      end
      assign rdata = out_q;
    end else begin : g_direct
      assign rdata = rd_q;
    end
  endgenerate
endmodule

// File: rtl/tpr_clash.sv
// Cross-port address collision detector, delayed to the read latency.
module tpr_clash #(
  parameter int AW  = 10,
  parameter int LAT = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_a,
  input  logic [AW-1:0] waddr_a,
  input  logic [AW-1:0] raddr_a,
  input  logic          we_b,
  input  logic [AW-1:0] waddr_b,
  input  logic [AW-1:0] raddr_b,
  output logic          flag
);
  logic hit;

  assign hit = (we_a && ((we_b && (waddr_a == waddr_b)) || (waddr_a == raddr_b)))
            || (we_b && (waddr_b == raddr_a));

  generate
    if (LAT == 1) begin : g_one
      logic q;
      always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= hit;
      end
      assign flag = q;
    end else begin : g_many
      logic [LAT-1:0] pipe;
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[LAT-2:0], hit};
      end
      assign flag = pipe[LAT-1];
    end
  endgenerate
endmodule

// File: rtl/twin_port_ram.sv
module twin_port_ram
  import tpr_pkg::*;
#(
  parameter int     AW      = 10,
  parameter int     DW      = 16,
  parameter wmode_e WMODE   = WM_READ_FIRST,
  parameter bit     OUT_REG = 1'b0,
  parameter logic [(1<<AW)*DW-1:0] INIT_IMAGE = '0
) (
  input  logic          clk_a,
  input  logic          rst_a,
  input  logic          we_a,
  input  logic [AW-1:0] waddr_a,
  input  logic [AW-1:0] raddr_a,
  input  logic [DW-1:0] wdata_a,
  output logic [DW-1:0] rdata_a,
  input  logic          clk_b,
  input  logic          rst_b,
  input  logic          we_b,
  input  logic [AW-1:0] waddr_b,
  input  logic [AW-1:0] raddr_b,
  input  logic [DW-1:0] wdata_b,
  output logic [DW-1:0] rdata_b,
  output logic          collide_o
);
  localparam int LAT = OUT_REG ? 2 : 1;

  // bank_a taps: A read, B read, B write address
  logic [DW-1:0] ba_ra, ba_rb, ba_wb;
  // bank_b taps: A read, B read, A write address
  logic [DW-1:0] bb_ra, bb_rb, bb_wa;
  logic          we_b_eff;

  // Port A wins a same-address double write.
  assign we_b_eff = we_b && !(we_a && (waddr_a == waddr_b));

  tpr_bank #(.AW(AW), .DW(DW), .INIT_IMAGE(INIT_IMAGE)) bank_a_i (
    .clk(clk_a), .we(we_a), .waddr(waddr_a), .wword(wdata_a ^ bb_wa),
    .tap0_addr(raddr_a), .tap1_addr(raddr_b), .tap2_addr(waddr_b),
    .tap0_word(ba_ra), .tap1_word(ba_rb), .tap2_word(ba_wb)
  );

  tpr_bank #(.AW(AW), .DW(DW), .INIT_IMAGE('0)) bank_b_i (
    .clk(clk_b), .we(we_b_eff), .waddr(waddr_b), .wword(wdata_b ^ ba_wb),
    .tap0_addr(raddr_a), .tap1_addr(raddr_b), .tap2_addr(waddr_a),
    .tap0_word(bb_ra), .tap1_word(bb_rb), .tap2_word(bb_wa)
  );

  tpr_rdport #(.AW(AW), .DW(DW), .WMODE(WMODE), .OUT_REG(OUT_REG)) port_a_i (
    .clk(clk_a), .rst(rst_a), .we(we_a), .waddr(waddr_a), .raddr(raddr_a),
    .wdata(wdata_a), .word(ba_ra ^ bb_ra), .rdata(rdata_a)
  );

  tpr_rdport #(.AW(AW), .DW(DW), .WMODE(WMODE), .OUT_REG(OUT_REG)) port_b_i (
    .clk(clk_b), .rst(rst_b), .we(we_b), .waddr(waddr_b), .raddr(raddr_b),
    .wdata(wdata_b), .word(ba_rb ^ bb_rb), .rdata(rdata_b)
  );

  tpr_clash #(.AW(AW), .LAT(LAT)) clash_i (
    .clk(clk_a), .rst(rst_a),
    .we_a(we_a), .waddr_a(waddr_a), .raddr_a(raddr_a),
    .we_b(we_b), .waddr_b(waddr_b), .raddr_b(raddr_b),
    .flag(collide_o)
  );
endmodule

// File: rtl/tpr_checker.sv
module tpr_checker
  import tpr_pkg::*;
#(
  parameter int     AW      = 10,
  parameter int     DW      = 16,
  parameter wmode_e WMODE   = WM_READ_FIRST,
  parameter bit     OUT_REG = 1'b0
) (
  input logic          clk_a,
  input logic          rst_a,
  input logic          we_a,
  input logic [AW-1:0] waddr_a,
  input logic [AW-1:0] raddr_a,
  input logic [DW-1:0] wdata_a,
  input logic [DW-1:0] rdata_a,
  input logic          clk_b,
  input logic          rst_b,
  input logic          we_b,
  input logic [AW-1:0] waddr_b,
  input logic [AW-1:0] raddr_b,
  input logic [DW-1:0] rdata_b,
  input logic          collide_o
);
  logic cross_hit;
  assign cross_hit = (we_a && (waddr_a == raddr_b)) || (we_b && (waddr_b == raddr_a))
                  || (we_a && we_b && (waddr_a == waddr_b));

  // R8: reset clears read data and the flag
  assert_reset_clear_a_R8: assert property (@(posedge clk_a)
    rst_a |=> (rdata_a == '0) && !collide_o);
  assert_reset_clear_b_R8: assert property (@(posedge clk_b)
    rst_b |=> (rdata_b == '0));

  generate
    if (!OUT_REG) begin : g_lat1
      // R4: double write to one address is flagged
      assert_double_write_flag_R4: assert property (@(posedge clk_a) disable iff (rst_a)
        (we_a && we_b && (waddr_a == waddr_b)) |=> collide_o);
      // R5: no writes at all means no flag
      assert_no_write_no_flag_R5: assert property (@(posedge clk_a) disable iff (rst_a)
        (!we_a && !we_b) |=> !collide_o);
      if (WMODE == WM_WRITE_THROUGH) begin : g_wt
        // R3: same-port read of written address returns new data
        assert_wt_forward_R3: assert property (@(posedge clk_a) disable iff (rst_a)
          (we_a && (waddr_a == raddr_a) && !cross_hit) |=> (rdata_a == $past(wdata_a)));
      end
    end
  endgenerate
endmodule

bind twin_port_ram tpr_checker #(.AW(AW), .DW(DW), .WMODE(WMODE), .OUT_REG(OUT_REG)) chk_i (
  .clk_a(clk_a), .rst_a(rst_a), .we_a(we_a), .waddr_a(waddr_a), .raddr_a(raddr_a),
  .wdata_a(wdata_a), .rdata_a(rdata_a), .clk_b(clk_b), .rst_b(rst_b), .we_b(we_b),
  .waddr_b(waddr_b), .raddr_b(raddr_b), .rdata_b(rdata_b), .collide_o(collide_o)
);

// File: tb/twin_port_ram_tb_top.sv
`timescale 1ns/1ps
module twin_port_ram_tb_top;
  import tpr_pkg::*;

  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  function automatic logic [DW-1:0] init_word(int i);
    return DW'((i * 37 + 5) ^ 8'hA0);
  endfunction

  function automatic logic [DEPTH*DW-1:0] build_image();
    logic [DEPTH*DW-1:0] img;
    for (int i = 0; i < DEPTH; i++) img[i*DW +: DW] = init_word(i);
    return img;
  endfunction

  localparam logic [DEPTH*DW-1:0] IMG = build_image();

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst;
  logic          we_a, we_b;
  logic [AW-1:0] wa_a, ra_a, wa_b, ra_b;
  logic [DW-1:0] wd_a, wd_b;
  logic [DW-1:0] rd_a, rd_b, rf_rd_a, rf_rd_b;
  logic          coll, rf_coll;

  // write-through, single-cycle latency
  twin_port_ram #(.AW(AW), .DW(DW), .WMODE(WM_WRITE_THROUGH), .OUT_REG(1'b0), .INIT_IMAGE(IMG)) dut_i (
    .clk_a(clk), .rst_a(rst), .we_a(we_a), .waddr_a(wa_a), .raddr_a(ra_a), .wdata_a(wd_a), .rdata_a(rd_a),
    .clk_b(clk), .rst_b(rst), .we_b(we_b), .waddr_b(wa_b), .raddr_b(ra_b), .wdata_b(wd_b), .rdata_b(rd_b),
    .collide_o(coll));

  // read-first, output register stage
  twin_port_ram #(.AW(AW), .DW(DW), .WMODE(WM_READ_FIRST), .OUT_REG(1'b1), .INIT_IMAGE(IMG)) dut_rf_i (
    .clk_a(clk), .rst_a(rst), .we_a(we_a), .waddr_a(wa_a), .raddr_a(ra_a), .wdata_a(wd_a), .rdata_a(rf_rd_a),
    .clk_b(clk), .rst_b(rst), .we_b(we_b), .waddr_b(wa_b), .raddr_b(ra_b), .wdata_b(wd_b), .rdata_b(rf_rd_b),
    .collide_o(rf_coll));

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] shadow [DEPTH];
  string cur_tag = "R1";

  typedef struct {
    logic          valid;
    logic          clash;
    logic [DW-1:0] a, b;
    string         tag_a, tag_b;
  } exp_t;

  exp_t e_wt, e_rf1, e_rf2;

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_due();
    if (e_wt.valid) begin
      chk(e_wt.clash ? "R4" : "R5", DW'(coll), DW'(e_wt.clash));
      if (!e_wt.clash) begin
        chk(e_wt.tag_a, rd_a, e_wt.a);
        chk(e_wt.tag_b, rd_b, e_wt.b);
      end
    end
    if (e_rf2.valid) begin
      chk(e_rf2.clash ? "R7 R4" : "R7 R5", DW'(rf_coll), DW'(e_rf2.clash));
      if (!e_rf2.clash) begin
        chk(e_rf2.tag_a, rf_rd_a, e_rf2.a);
        chk(e_rf2.tag_b, rf_rd_b, e_rf2.b);
      end
    end
  endtask

  task automatic step(logic wea, logic [AW-1:0] waa, logic [AW-1:0] raa, logic [DW-1:0] wda,
                      logic web, logic [AW-1:0] wab, logic [AW-1:0] rab, logic [DW-1:0] wdb);
    exp_t nw, nr;
    logic cl;
    @(negedge clk);
    check_due();
    we_a = wea; wa_a = waa; ra_a = raa; wd_a = wda;
    we_b = web; wa_b = wab; ra_b = rab; wd_b = wdb;
    cl = (wea && web && waa == wab) || (wea && waa == rab) || (web && wab == raa);
    nw.valid = 1'b1; nw.clash = cl; nr.valid = 1'b1; nr.clash = cl;
    nw.a = (wea && waa == raa) ? wda : shadow[raa];
    nw.b = (web && wab == rab) ? wdb : shadow[rab];
    nr.a = shadow[raa];
    nr.b = shadow[rab];
    nw.tag_a = (wea && waa == raa) ? "R3" : cur_tag;
    nw.tag_b = (web && wab == rab) ? "R3" : cur_tag;
    nr.tag_a = (wea && waa == raa) ? "R2" : "R7";
    nr.tag_b = (web && wab == rab) ? "R2" : "R7";
    if (web) shadow[wab] = wdb;
    if (wea) shadow[waa] = wda;  // R6: A overrides B
    e_wt  = nw;
    e_rf2 = e_rf1;
    e_rf1 = nr;
  endtask

  task automatic idle(logic [AW-1:0] raa, logic [AW-1:0] rab);
    step(1'b0, '0, raa, '0, 1'b0, '0, rab, '0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) shadow[i] = init_word(i);
    e_wt.valid = 1'b0; e_rf1.valid = 1'b0; e_rf2.valid = 1'b0;
    rst = 1'b1;
    we_a = 1'b0; we_b = 1'b0; wa_a = '0; ra_a = 4'd3; wd_a = '0;
    wa_b = '0; ra_b = 4'd7; wd_b = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset state
    chk("R8", rd_a, '0);
    chk("R8", rd_b, '0);
    chk("R8", rf_rd_a, '0);
    chk("R8", rf_rd_b, '0);
    chk("R8", DW'(coll), '0);
    chk("R8", DW'(rf_coll), '0);
    rst = 1'b0;

    // R9: preloaded image, every word from both ports
    cur_tag = "R9";
    for (int i = 0; i < DEPTH; i++) idle(AW'(i), AW'(DEPTH - 1 - i));

    // R3 / R2: same-port write and read of every address, other port on a far word
    cur_tag = "R1";
    for (int i = 0; i < DEPTH; i++)
      step(1'b1, AW'(i), AW'(i), DW'(8'h3C ^ i), 1'b0, '0, AW'(i + 8), '0);
    for (int i = 0; i < DEPTH; i++)
      step(1'b0, '0, AW'(i + 8), '0, 1'b1, AW'(i), AW'(i), DW'(8'hC5 + i));

    // R1: write on A, read back on B; write on B, read back on A
    for (int i = 0; i < DEPTH; i++) begin
      step(1'b1, AW'(i), AW'(i + 1), DW'(i * 11), 1'b0, '0, AW'(i + 2), '0);
      idle(AW'(i + 5), AW'(i));
    end

    // R6 / R4: double write to each address, then read back
    for (int i = 0; i < DEPTH; i++) begin
      step(1'b1, AW'(i), AW'(i + 3), DW'(8'hA0 | i), 1'b1, AW'(i), AW'(i + 5), DW'(8'h50 | i));
      cur_tag = "R6";
      idle(AW'(i), AW'(i));
      cur_tag = "R1";
    end

    // R4: cross write/read in both directions
    for (int i = 0; i < DEPTH; i++) begin
      step(1'b1, AW'(i), AW'(i + 1), DW'(i), 1'b0, '0, AW'(i), '0);
      step(1'b0, '0, AW'(i), '0, 1'b1, AW'(i), AW'(i + 2), DW'(i + 99));
    end

    // mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0], AW'(r[4:1]), AW'(r[8:5]), DW'(r[16:9]),
           r[17], AW'(r[21:18]), AW'(r[25:22]), DW'({r[31:26], r[1:0]}));
    end

    idle('0, '1);
    idle('1, '0);
    idle('0, '0);
    finish_run();
  end
endmodule